// File: doc/BRIEF.md
# Delay Line Length Calibrator

This block is a hardware sequencer that calibrates a tapped delay line. The goal is for one clock period to land inside the span of the available taps. It programs the delay line through a small register-style write interface: a control register and a configuration register. It reads the configuration word back to observe the measured length pattern.

Calibration starts on a start pulse. The block tries unit-delay settings in ascending order from zero. For each setting it programs the line in measurement mode and waits a bounded number of cycles for the length-valid flag. It accepts the first setting whose length pattern is non-zero and below the all-taps value.

On success the block stores the chosen unit and the highest usable tap index, taken from the most significant set bit of the accepted pattern, and pulses `done`. If every setting is rejected it pulses `error` and keeps the previously stored results.

Top module: `tapline_calibrator`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `error`, `unit_out`, `max_tap`, `ctrl_wr` and `cfg_wr` are all zero.
- R2: A `start` pulse seen while idle launches calibration. `busy` is high from the next cycle until the final cycle, inclusive. A `start` seen while busy has no effect on the run's length or result.
- R3: Each unit step issues exactly three writes, one per cycle, back to back, never with both strobes high:
  - a control write of 0x2 (bit 1 = sampler enable only);
  - a configuration write with the unit at bits 14:8 and the tap select at bits 3:0 forced to 12;
  - a control write of 0x3 (bit 0 = delay enable, bit 1 = sampler enable).
- R4: Unit values are tried in ascending order starting at 0, and the last one tried is 127.
- R5: The length field (bits 27:16 of the read-back word) is only evaluated in a cycle where the valid flag (bit 31) is high.
- R6: A valid length is accepted when it is greater than 0 and less than 2048. A length of 0 or of 2048 and above moves the search to the next unit.
- R7: From the cycle after the final control write, the flag is sampled for at most `timeout_cycles` cycles; a value of 0 counts as 1. The count restarts for every unit. A unit whose flag does not appear in that window is skipped, and no error is raised for it.
- R8: On acceptance, `unit_out` takes the unit and `max_tap` takes the bit index of the highest set bit of the length. `done` is high for exactly one cycle.
- R9: If no unit from 0 to 127 is accepted, `error` is high for exactly one cycle, `done` stays low, and `unit_out` and `max_tap` keep their earlier values.
- R10: A run lasts 3 + W cycles per unit tried plus one final cycle, where W is the number of wait cycles for that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Calibration launch pulse |
| timeout_cycles | input | 16 | Wait window per unit, in cycles (0 treated as 1) |
| cfg_rdata | input | 32 | Configuration word read back from the delay line |
| ctrl_wr | output | 1 | Control register write strobe |
| cfg_wr | output | 1 | Configuration register write strobe |
| wr_data | output | 32 | Write data for either register |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| unit_out | output | 7 | Selected unit-delay setting |
| max_tap | output | 4 | Highest usable tap index |

## Verification
Each unit step costs three write cycles. Wait cycles then follow: one more than the delay-line model's response latency, or the full timeout window when the flag is late or absent. A single final cycle carries `done` or `error`. The bench computes this total for every scenario from its own table of latencies and lengths. It counts the `busy` cycles at falling edges, starting one edge after `start` is sampled, and requires an exact match. `done` and `error` are counted inside the same window, so a pulse that is early, late or doubled shows up as a count mismatch. The model also checks each write in the cycle it is strobed.

// File: rtl/dlcal_pkg.sv
// Package: shared field positions and state types for the delay line
// length calibrator. Bit positions are fixed by the delay-line register
// layout that the neighbouring block decodes.
package dlcal_pkg;
    localparam int WORD_W        = 32;
    localparam int CTRL_DEN_BIT  = 0;   // delay enable
    localparam int CTRL_SEN_BIT  = 1;   // sampler enable
    localparam int CFG_SEL_LSB   = 0;
    localparam int CFG_UNIT_LSB  = 8;
    localparam int CFG_LEN_LSB   = 16;
    localparam int CFG_VALID_BIT = 31;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARM, ST_CFG, ST_ENA, ST_WAIT, ST_FIN
    } cal_state_t;

    typedef enum logic [1:0] {
        WR_NONE, WR_ARM, WR_CFG, WR_ENA
    } wr_step_t;
endpackage

// File: rtl/dlcal_bus_fmt.sv
// Module: dlcal_bus_fmt
// Turns the current write step and unit into one register write.
// Assumes: UNIT_W fits in bits 14:8 and SEL_W in bits 3:0.
module dlcal_bus_fmt
    import dlcal_pkg::*;
#(
    parameter int UNIT_W   = 7,
    parameter int SEL_W    = 4,
    parameter int SEL_MEAS = 12
) (
    input  wr_step_t            step,
    input  logic [UNIT_W-1:0]   unit,
    output logic                ctrl_wr,
    output logic                cfg_wr,
    output logic [WORD_W-1:0]   wr_data
);
    // Purpose: decode the step into strobes and write data.
    always_comb begin
        ctrl_wr = 1'b0;
        cfg_wr  = 1'b0;
        wr_data = '0;
        unique case (step)
            WR_ARM: begin
                ctrl_wr                = 1'b1;
                wr_data[CTRL_SEN_BIT]  = 1'b1;
            end
            WR_CFG: begin
                cfg_wr                            = 1'b1;
                wr_data[CFG_UNIT_LSB +: UNIT_W]   = unit;
                wr_data[CFG_SEL_LSB +: SEL_W]     = SEL_W'(SEL_MEAS);
            end
            WR_ENA: begin
                ctrl_wr                = 1'b1;
                wr_data[CTRL_SEN_BIT]  = 1'b1;
                wr_data[CTRL_DEN_BIT]  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dlcal_wait_timer.sv
// Module: dlcal_wait_timer
// Counts wait cycles for one unit step and flags the last cycle of the
// window. A limit of 0 behaves as 1. Cleared whenever not waiting.
module dlcal_wait_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;
    logic [TO_W-1:0] last;

    // Purpose: index of the final sampled cycle in the window.
    assign last    = (limit == '0) ? '0 : limit - 1'b1;
    assign expired = run && (cnt >= last);

    // Purpose: count wait cycles; restart from zero for each unit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt < last) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: the window starts from zero for every new unit
    p_window_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/dlcal_len_judge.sv
// Module: dlcal_len_judge
// Extracts the length pattern and valid flag from the read-back word,
// decides acceptance and finds the highest set bit.
module dlcal_len_judge
    import dlcal_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int NTAPS = 11,
    parameter int TAP_W = 4
) (
    input  logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              accept,
    output logic [TAP_W-1:0]  msb_idx
);
    localparam logic [LEN_W:0] LEN_LIMIT = (LEN_W+1)'(2 ** NTAPS);

    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] top_bit;
    logic             unused_bits;

    assign len         = word[CFG_LEN_LSB +: LEN_W];
    assign valid       = word[CFG_VALID_BIT];
    assign unused_bits = ^{word[30:28], word[15:0]};

    // Purpose: accept a valid, non-empty, partial-period pattern.
    assign accept = valid && (|len) && ({1'b0, len} < LEN_LIMIT);

    // Purpose: one-hot mark of the highest set bit, one slice per bit.
    for (genvar g = 0; g < LEN_W; g++) begin : g_top
        if (g == LEN_W - 1) begin : g_msb
            assign top_bit[g] = len[g];
        end else begin : g_low
            assign top_bit[g] = len[g] && !(|len[LEN_W-1:g+1]);
        end
    end

    // Purpose: encode the one-hot mark into a bit index.
    always_comb begin
        msb_idx = '0;
        for (int i = 0; i < LEN_W; i++) begin
            if (top_bit[i]) msb_idx = msb_idx | TAP_W'(i);
        end
    end
endmodule

// File: rtl/tapline_calibrator.sv
// Module: tapline_calibrator
// Sweeps the unit-delay setting from 0 upward until the delay line
// reports a partial-period length, then stores the unit and the highest
// usable tap. Assumes: timeout_cycles is held stable during a run and the
// read-back word reflects register writes of earlier cycles.
module tapline_calibrator
    import dlcal_pkg::*;
#(
    parameter int UNIT_W = 7,
    parameter int SEL_W  = 4,
    parameter int LEN_W  = 12,
    parameter int NTAPS  = 11,
    parameter int TO_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [TO_W-1:0]      timeout_cycles,
    input  logic [31:0]          cfg_rdata,
    output logic                 ctrl_wr,
    output logic                 cfg_wr,
    output logic [31:0]          wr_data,
    output logic                 busy,
    output logic                 done,
    output logic                 error,
    output logic [UNIT_W-1:0]    unit_out,
    output logic [$clog2(LEN_W)-1:0] max_tap
);
    localparam int                SEL_MEAS  = NTAPS + 1;
    localparam int                TAP_W     = $clog2(LEN_W);
    localparam logic [UNIT_W-1:0] UNIT_LAST = '1;

    cal_state_t         state;
    wr_step_t           step;
    logic [UNIT_W-1:0]  unit_cur;
    logic               ok_q;
    logic               len_valid;
    logic               len_accept;
    logic [TAP_W-1:0]   len_msb;
    logic               wait_over;

    // Purpose: map the sequencer state onto a register write step.
    always_comb begin
        unique case (state)
            ST_ARM:  step = WR_ARM;
            ST_CFG:  step = WR_CFG;
            ST_ENA:  step = WR_ENA;
            default: step = WR_NONE;
        endcase
    end

    dlcal_bus_fmt #(
        .UNIT_W   (UNIT_W),
        .SEL_W    (SEL_W),
        .SEL_MEAS (SEL_MEAS)
    ) u_fmt (
        .step    (step),
        .unit    (unit_cur),
        .ctrl_wr (ctrl_wr),
        .cfg_wr  (cfg_wr),
        .wr_data (wr_data)
    );

    dlcal_wait_timer #(
        .TO_W (TO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_WAIT),
        .limit   (timeout_cycles),
        .expired (wait_over)
    );

    dlcal_len_judge #(
        .LEN_W (LEN_W),
        .NTAPS (NTAPS),
        .TAP_W (TAP_W)
    ) u_judge (
        .word    (cfg_rdata),
        .valid   (len_valid),
        .accept  (len_accept),
        .msb_idx (len_msb)
    );

    // Purpose: sequence the unit sweep and hold the calibration result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            unit_cur <= '0;
            ok_q     <= 1'b0;
            unit_out <= '0;
            max_tap  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        unit_cur <= '0;
                        state    <= ST_ARM;
                    end
                end
                ST_ARM:  state <= ST_CFG;
                ST_CFG:  state <= ST_ENA;
                ST_ENA:  state <= ST_WAIT;
                ST_WAIT: begin
                    if (len_valid && len_accept) begin
                        unit_out <= unit_cur;
                        max_tap  <= len_msb;
                        ok_q     <= 1'b1;
                        state    <= ST_FIN;
                    end else if (len_valid || wait_over) begin
                        if (unit_cur == UNIT_LAST) begin
                            ok_q  <= 1'b0;
                            state <= ST_FIN;
                        end else begin
                            unit_cur <= unit_cur + 1'b1;
                            state    <= ST_ARM;
                        end
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: status outputs decoded from the sequencer state.
    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_FIN) && ok_q;
    assign error = (state == ST_FIN) && !ok_q;

    // R3: sampler-only control write is followed by the config write
    p_arm_then_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data == 32'h2) |=> cfg_wr);
    // R3: config write is followed by the enabling control write
    p_cfg_then_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (ctrl_wr && wr_data == 32'h3));
    // R3: tap select forced to the measurement value
    p_sel_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> (wr_data[3:0] == SEL_W'(SEL_MEAS)));
    // R3: never two strobes at once
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && cfg_wr));
    // R2: completion pulses only while busy
    p_end_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> busy);
    // R8: done is a single-cycle pulse, exclusive with error
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !error);
    // R8: reported tap lies inside the delay line
    p_tap_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (max_tap < TAP_W'(NTAPS)));
    // R9: a failed sweep leaves the stored result untouched
    p_keep_on_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> ($stable(unit_out) && $stable(max_tap)));
endmodule

// File: tb/tapline_calibrator_test.sv
module tapline_calibrator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tmo = 16'd8;
    logic [31:0] cfg_rdata;
    logic        ctrl_wr, cfg_wr;
    logic [31:0] wr_data;
    logic        busy, done, error;
    logic [6:0]  unit_out;
    logic [3:0]  max_tap;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    tapline_calibrator uut (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_cycles(tmo),
        .cfg_rdata(cfg_rdata), .ctrl_wr(ctrl_wr), .cfg_wr(cfg_wr),
        .wr_data(wr_data), .busy(busy), .done(done), .error(error),
        .unit_out(unit_out), .max_tap(max_tap)
    );

    // ---------------- behavioural delay-line model ----------------
    int          lat_tab [128];   // -1: flag never appears
    logic [11:0] len_tab [128];
    logic        clr_stub = 1'b0;
    logic [6:0]  st_unit;
    logic [3:0]  st_sel;
    logic [11:0] st_len;
    logic        st_valid, st_armed;
    int          st_cnt, phase, exp_unit, proto_err;

    assign cfg_rdata = {st_valid, 3'b000, st_len, 1'b0, st_unit, 4'b0000, st_sel};

    always @(posedge clk) begin
        if (!rst_n || clr_stub) begin
            st_unit <= '0; st_sel <= '0; st_len <= '0; st_valid <= 1'b0;
            st_armed <= 1'b0; st_cnt <= 0; phase <= 0; exp_unit <= 0; proto_err <= 0;
        end else begin
            if (ctrl_wr && cfg_wr) proto_err <= proto_err + 1;
            else if (ctrl_wr) begin
                st_valid <= 1'b0;
                st_armed <= 1'b0;
                if (wr_data == 32'h2) begin
                    if (phase != 0) proto_err <= proto_err + 1;
                    phase <= 1;
                end else if (wr_data == 32'h3) begin
                    if (phase != 2) proto_err <= proto_err + 1;
                    phase    <= 0;
                    exp_unit <= exp_unit + 1;
                    if (lat_tab[st_unit] == 0) st_valid <= 1'b1;
                    else if (lat_tab[st_unit] > 0) begin
                        st_armed <= 1'b1;
                        st_cnt   <= lat_tab[st_unit];
                    end
                end else proto_err <= proto_err + 1;
            end else if (cfg_wr) begin
                if (phase != 1 || wr_data[3:0] != 4'd12 ||
                    wr_data[14:8] != exp_unit[6:0]) proto_err <= proto_err + 1;
                st_unit  <= wr_data[14:8];
                st_sel   <= wr_data[3:0];
                st_len   <= len_tab[wr_data[14:8]];
                st_valid <= 1'b0;
                phase    <= 2;
            end else if (st_armed) begin
                if (st_cnt == 1) begin
                    st_valid <= 1'b1;
                    st_armed <= 1'b0;
                end else st_cnt <= st_cnt - 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int msb_of(input logic [11:0] v);
        int r = 0;
        for (int i = 0; i < 12; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic fill(input int lat, input logic [11:0] len);
        for (int u = 0; u < 128; u++) begin
            lat_tab[u] = lat;
            len_tab[u] = len;
        end
    endtask

    // Expected run length and result from the requirements (R6, R7, R10)
    task automatic predict(output int cyc, output bit ok, output int eu, output int et);
        int te = (tmo == 0) ? 1 : int'(tmo);
        cyc = 0; ok = 1'b0; eu = 0; et = 0;
        for (int u = 0; u < 128; u++) begin
            bit seen = (lat_tab[u] >= 0) && (lat_tab[u] < te);
            cyc += 3 + (seen ? lat_tab[u] + 1 : te);
            if (seen && len_tab[u] != 0 && len_tab[u] < 12'h800) begin
                ok = 1'b1; eu = u; et = msb_of(len_tab[u]);
                break;
            end
        end
        cyc += 1;
    endtask

    task automatic run_cal(input bit restart_mid, output int cyc, output int nd, output int ne);
        clr_stub = 1'b1;
        @(negedge clk);
        clr_stub = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; nd = 0; ne = 0;
        while (busy && cyc < 20000) begin
            if (done)  nd++;
            if (error) ne++;
            cyc++;
            start = restart_mid && (cyc == 3 || cyc == 10);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic run_and_check(input string tag, input bit restart_mid, input int keep_u, input int keep_t);
        int cyc, nd, ne, ecyc, eu, et;
        bit ok;
        predict(ecyc, ok, eu, et);
        run_cal(restart_mid, cyc, nd, ne);
        chk("R10", {tag, " busy cycles"}, cyc, ecyc);
        chk("R3",  {tag, " write sequence errors"}, proto_err, 0);
        chk("R4",  {tag, " units tried"}, exp_unit, ok ? eu + 1 : 128);
        chk("R8",  {tag, " done pulses"}, nd, ok ? 1 : 0);
        chk("R9",  {tag, " error pulses"}, ne, ok ? 0 : 1);
        chk(ok ? "R8" : "R9", {tag, " unit_out"}, int'(unit_out), ok ? eu : keep_u);
        chk(ok ? "R8" : "R9", {tag, " max_tap"},  int'(max_tap),  ok ? et : keep_t);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;  // R1
        chk("R1", "busy",     int'(busy), 0);
        chk("R1", "done",     int'(done), 0);
        chk("R1", "error",    int'(error), 0);
        chk("R1", "unit_out", int'(unit_out), 0);
        chk("R1", "max_tap",  int'(max_tap), 0);
        chk("R1", "strobes",  int'(ctrl_wr | cfg_wr), 0);
    endtask

    task automatic t_first_fit;  // R5 R6 R8: full-period patterns skipped
        tmo = 16'd8;
        fill(2, 12'hFFF);
        lat_tab[5] = 0; len_tab[5] = 12'h01F;
        run_and_check("first_fit", 1'b0, 0, 0);
    endtask

    task automatic t_edges;  // R6: zero and 2048 rejected, 2047 accepted
        tmo = 16'd8;
        fill(1, 12'h000);
        len_tab[10] = 12'h800;
        len_tab[11] = 12'h7FF;
        run_and_check("len_edges", 1'b0, 0, 0);
    endtask

    task automatic t_timeout;  // R7 R5: late flag skipped, last window cycle counts
        tmo = 16'd4;
        fill(-1, 12'h003);
        lat_tab[3] = 4;
        lat_tab[4] = 3; len_tab[4] = 12'h001;
        run_and_check("timeout", 1'b0, 0, 0);
    endtask

    task automatic t_timeout_zero;  // R7: zero window acts as one cycle
        tmo = 16'd0;
        fill(1, 12'h040);
        lat_tab[1] = 0;
        run_and_check("timeout_zero", 1'b0, 0, 0);
    endtask

    task automatic t_fail;  // R9: keeps previous result (unit 1, tap 6)
        tmo = 16'd8;
        fill(0, 12'hFFF);
        run_and_check("no_fit", 1'b0, 1, 6);
    endtask

    task automatic t_restart;  // R2: start while busy ignored
        tmo = 16'd8;
        fill(2, 12'hFFF);
        lat_tab[5] = 0; len_tab[5] = 12'h01F;
        run_and_check("start_busy", 1'b1, 0, 0);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        fill(0, 12'h000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_fit();
        t_edges();
        t_timeout();
        t_timeout_zero();
        t_fail();
        t_restart();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule